// File: doc/BRIEF.md
# Frame Sync Lock Detector

This block decides whether a serial receiver is aligned to a repeating frame. The serial clock domain gives one strobe per bit time. A separate correlator raises a pulse when it sees the frame synchronization pattern. The block counts bit positions inside a frame of fixed length, keeps a candidate frame-start position, and reports lock with hysteresis. Three matching syncs at the same position in consecutive frames are needed to acquire lock. Two consecutive frames without a sync at the expected position are needed to lose it.

While the block is locked, syncs that arrive away from the expected position are ignored. This keeps false pattern matches inside the payload from disturbing alignment. A sticky error flag records every clock spent unlocked. Software clears the flag by writing 0 to it.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and cannot apply back-pressure. The sync pulse only counts in a cycle where the bit strobe is high.

Top module: `fsl_lock_det`

## Requirements
- R1: During reset and before the first clock edge after it, `locked`=0, `start_pos`=0, `cur_pos`=0 and `lock_err`=0.
- R2: While unlocked, `locked` rises after the third consecutive frame in which a sync is seen at the same bit position. That position is reported on `start_pos` from the first of those syncs onward.
- R3: While locked, a single frame whose expected position has no sync keeps the lock. The second consecutive such frame drops `locked` to 0 at the strobe of that expected position.
- R4: While locked, a sync at any position other than `start_pos` changes neither `locked` nor `start_pos`.
- R5: While locked, a sync at the expected position clears the miss count. A miss, then a hit, then a miss leaves the block locked.
- R6: On every clock edge where `locked` is 0, `lock_err` becomes 1. This set wins over a simultaneous clear write.
- R7: While locked, a clear write (`err_wr`=1, `err_wdata`=0) brings `lock_err` to 0 after the clock edge. A write with `err_wdata`=1 leaves `lock_err` unchanged.
- R8: While acquiring, a sync at a position different from the candidate restarts acquisition at the new position with a count of one.
- R9: While acquiring, a strobe at the candidate position without a sync discards the candidate. Once the candidate is discarded, or once lock is lost, the next sync at any position becomes the first candidate.
- R10: `cur_pos` advances by one on each edge where `bit_stb`=1, wraps from FRAME_LEN-1 to 0, and holds otherwise. `sync_det` has no effect when `bit_stb`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One pulse per serial bit time |
| sync_det | input | 1 | Sync pattern seen at the current bit; sampled only with bit_stb |
| err_wr | input | 1 | Software write strobe to the lock-error flag |
| err_wdata | input | 1 | Write value; 0 clears the flag, 1 does nothing |
| locked | output | 1 | Receiver aligned to the frame |
| start_pos | output | POS_W | Expected (or candidate) frame-start bit position |
| cur_pos | output | POS_W | Bit position of the next strobe in the frame |
| lock_err | output | 1 | Sticky flag: block has been unlocked since the last clear |

## Verification
Every output is a register. A strobe, sync or write applied before a clock edge shows its effect on `cur_pos`, `start_pos` and `locked` right after that same edge. `lock_err` follows the `locked` value held before that edge, so after a loss of lock it rises one clock after `locked` falls. The bench drives inputs on the falling edge and advances its reference model on the rising edge. It compares all outputs on the next falling edge, so each result is sampled exactly one edge after its cause. The directed checks are placed at frame boundaries, where the frame count set by the requirement is complete.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

  // Acquisition / tracking phase of the lock detector
  typedef enum logic [1:0] {
    ACQ_HUNT   = 2'd0,  // no candidate position
    ACQ_VERIFY = 2'd1,  // candidate held, counting matching frames
    ACQ_LOCK   = 2'd2   // aligned, counting misses
  } acq_state_e;

  // Smallest width able to hold the value n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/fsl_pos_ctr.sv
module fsl_pos_ctr #(
  parameter int FRAME_LEN = 64,
  localparam int POS_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  output logic [POS_W-1:0] pos
);

  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_LEN - 1);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_d;

  always_comb begin
    pos_d = pos_q;
    if (stb) begin
      if (pos_q == POS_LAST) pos_d = '0;
      else                   pos_d = pos_q + POS_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos = pos_q;

endmodule

// File: rtl/fsl_acq.sv
module fsl_acq
  import fsl_pkg::*;
#(
  parameter int FRAME_LEN   = 64,
  parameter int ACQ_HITS    = 3,
  parameter int LOSS_MISSES = 2,
  localparam int POS_W  = $clog2(FRAME_LEN),
  localparam int HIT_W  = cnt_width(ACQ_HITS),
  localparam int MISS_W = cnt_width(LOSS_MISSES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             sync,
  input  logic [POS_W-1:0] pos,
  output logic             locked,
  output logic [POS_W-1:0] cand
);

  localparam logic [HIT_W-1:0]  HIT_LAST  = HIT_W'(ACQ_HITS - 1);
  localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(LOSS_MISSES - 1);
  localparam logic [HIT_W-1:0]  HIT_ONE   = HIT_W'(1);

  acq_state_e        st_q, st_d;
  logic [POS_W-1:0]  cand_q, cand_d;
  logic [HIT_W-1:0]  hit_q, hit_d;
  logic [MISS_W-1:0] miss_q, miss_d;

  logic at_cand;
  assign at_cand = stb && (pos == cand_q);

  always_comb begin
    st_d   = st_q;
    cand_d = cand_q;
    hit_d  = hit_q;
    miss_d = miss_q;
    unique case (st_q)
      ACQ_HUNT: begin
        if (stb && sync) begin
          cand_d = pos;
          hit_d  = HIT_ONE;
          miss_d = '0;
          st_d   = (ACQ_HITS <= 1) ? ACQ_LOCK : ACQ_VERIFY;
        end
      end
      ACQ_VERIFY: begin
        if (at_cand && sync) begin
          if (hit_q == HIT_LAST) begin
            st_d   = ACQ_LOCK;
            miss_d = '0;
          end else begin
            hit_d = hit_q + HIT_ONE;
          end
        end else if (stb && sync) begin
          // sync somewhere else: new candidate, count restarts
          cand_d = pos;
          hit_d  = HIT_ONE;
        end else if (at_cand) begin
          // candidate missed its frame: give it up
          st_d  = ACQ_HUNT;
          hit_d = '0;
        end
      end
      ACQ_LOCK: begin
        if (at_cand) begin
          if (sync) begin
            miss_d = '0;
          end else if (miss_q == MISS_LAST) begin
            st_d   = ACQ_HUNT;
            hit_d  = '0;
            miss_d = '0;
          end else begin
            miss_d = miss_q + MISS_W'(1);
          end
        end
      end
      default: begin
        st_d  = ACQ_HUNT;
        hit_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ACQ_HUNT;
      cand_q <= '0;
      hit_q  <= '0;
      miss_q <= '0;
    end else begin
      st_q   <= st_d;
      cand_q <= cand_d;
      hit_q  <= hit_d;
      miss_q <= miss_d;
    end
  end

  assign locked = (st_q == ACQ_LOCK);
  assign cand   = cand_q;

endmodule

// File: rtl/fsl_err_flag.sv
module fsl_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic locked,
  input  logic clr_wr,
  input  logic clr_wdata,
  output logic err
);

  logic err_q;
  logic clr_req;

  assign clr_req = clr_wr && !clr_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (!locked) err_q <= 1'b1;  // set dominates
    else if (clr_req) err_q <= 1'b0;
  end

  assign err = err_q;

endmodule

// File: rtl/fsl_lock_det.sv
module fsl_lock_det #(
  parameter int FRAME_LEN   = 64,
  parameter int ACQ_HITS    = 3,
  parameter int LOSS_MISSES = 2,
  localparam int POS_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             sync_det,
  input  logic             err_wr,
  input  logic             err_wdata,
  output logic             locked,
  output logic [POS_W-1:0] start_pos,
  output logic [POS_W-1:0] cur_pos,
  output logic             lock_err
);

  logic [POS_W-1:0] pos_w;
  logic [POS_W-1:0] cand_w;
  logic             lock_w;

  fsl_pos_ctr #(.FRAME_LEN(FRAME_LEN)) u_pos (
    .clk  (clk),
    .rst_n(rst_n),
    .stb  (bit_stb),
    .pos  (pos_w)
  );

  fsl_acq #(
    .FRAME_LEN  (FRAME_LEN),
    .ACQ_HITS   (ACQ_HITS),
    .LOSS_MISSES(LOSS_MISSES)
  ) u_acq (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (bit_stb),
    .sync  (sync_det),
    .pos   (pos_w),
    .locked(lock_w),
    .cand  (cand_w)
  );

  fsl_err_flag u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .locked   (lock_w),
    .clr_wr   (err_wr),
    .clr_wdata(err_wdata),
    .err      (lock_err)
  );

  assign locked    = lock_w;
  assign start_pos = cand_w;
  assign cur_pos   = pos_w;

endmodule

// File: rtl/fsl_lock_det_chk.sv
module fsl_lock_det_chk #(
  parameter int FRAME_LEN = 64,
  localparam int POS_W = $clog2(FRAME_LEN)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_stb,
  input logic             sync_det,
  input logic             locked,
  input logic [POS_W-1:0] start_pos,
  input logic [POS_W-1:0] cur_pos,
  input logic             lock_err
);

  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);

  // R2
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(bit_stb) && $past(sync_det) && ($past(cur_pos) == $past(start_pos))));

  // R3
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> ($past(bit_stb) && !$past(sync_det) && ($past(cur_pos) == $past(start_pos))));

  // R4
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(start_pos));

  // R6
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> lock_err);

  // R7
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_err) |-> !$past(locked));

  // R10
  pos_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(cur_pos));

  // R10
  pos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && cur_pos == LAST) |=> (cur_pos == '0));

endmodule

bind fsl_lock_det fsl_lock_det_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_stb  (bit_stb),
  .sync_det (sync_det),
  .locked   (locked),
  .start_pos(start_pos),
  .cur_pos  (cur_pos),
  .lock_err (lock_err)
);

// File: tb/fsl_lock_det_tb_top.sv
module fsl_lock_det_tb_top;

  localparam int FL = 16;
  localparam int PW = $clog2(FL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0, sync_det = 1'b0, err_wr = 1'b0, err_wdata = 1'b0;
  logic locked, lock_err;
  logic [PW-1:0] start_pos, cur_pos;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference model
  int m_pos = 0, m_st = 0, m_cand = 0, m_hit = 0, m_miss = 0;
  bit m_err = 0;

  always #4 clk = ~clk;

  fsl_lock_det #(.FRAME_LEN(FL)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .sync_det(sync_det),
    .err_wr(err_wr), .err_wdata(err_wdata), .locked(locked),
    .start_pos(start_pos), .cur_pos(cur_pos), .lock_err(lock_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_step(input bit s, input bit y, input bit w, input bit d);
    bit old_lock = (m_st == 2);
    if (!old_lock) m_err = 1;
    else if (w && !d) m_err = 0;
    if (s) begin
      case (m_st)
        0: if (y) begin m_cand = m_pos; m_hit = 1; m_st = 1; end
        1: begin
          if (y && m_pos == m_cand) begin
            if (m_hit == 2) begin m_st = 2; m_miss = 0; end
            else m_hit++;
          end else if (y) begin
            m_cand = m_pos; m_hit = 1;
          end else if (m_pos == m_cand) begin
            m_st = 0; m_hit = 0;
          end
        end
        default: if (m_pos == m_cand) begin
          if (y) m_miss = 0;
          else if (m_miss == 1) begin m_st = 0; m_hit = 0; m_miss = 0; end
          else m_miss++;
        end
      endcase
      m_pos = (m_pos == FL - 1) ? 0 : m_pos + 1;
    end
  endfunction

  // apply inputs at negedge, model on posedge, compare at next negedge
  task automatic tick(input bit s, input bit y, input bit w, input bit d);
    bit_stb = s; sync_det = y; err_wr = w; err_wdata = d;
    @(posedge clk);
    model_step(s, y, w, d);
    @(negedge clk);
    chk("R10 cur_pos", int'(cur_pos), m_pos);
    chk("R2 locked", int'(locked), int'(m_st == 2));
    chk("R2 start_pos", int'(start_pos), m_cand);
    chk("R6 lock_err", int'(lock_err), int'(m_err));
  endtask

  task automatic frame(input int sp, input int xp);
    for (int i = 0; i < FL; i++) begin
      tick(1'b1, (m_pos == sp) || (m_pos == xp), 1'b0, 1'b0);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 locked", int'(locked), 0);
    chk("R1 start_pos", int'(start_pos), 0);
    chk("R1 cur_pos", int'(cur_pos), 0);
    chk("R1 lock_err", int'(lock_err), 0);
    rst_n = 1'b1;

    // R10: no strobe, sync ignored
    tick(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R10 hold", int'(cur_pos), 0);
    chk("R10 sync without strobe", int'(start_pos), 0);
    chk("R6 set after reset", int'(lock_err), 1);

    // R2 acquisition at position 5
    frame(5, -1);
    chk("R2 candidate", int'(start_pos), 5);
    frame(5, -1);
    chk("R2 two hits not locked", int'(locked), 0);
    frame(5, -1);
    chk("R2 locked after three", int'(locked), 1);

    // R7 clear and write-one
    tick(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R7 cleared", int'(lock_err), 0);
    tick(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R7 write one ignored", int'(lock_err), 0);

    // R4 stray sync while locked
    frame(5, 9);
    chk("R4 start_pos kept", int'(start_pos), 5);
    chk("R4 lock kept", int'(locked), 1);

    // R3 / R5 miss handling
    frame(-1, -1);
    chk("R3 single miss keeps lock", int'(locked), 1);
    frame(5, -1);
    frame(-1, -1);
    chk("R5 miss count reset", int'(locked), 1);
    frame(-1, -1);
    chk("R3 two misses drop lock", int'(locked), 0);
    chk("R6 set on unlock", int'(lock_err), 1);
    tick(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R6 set wins over clear", int'(lock_err), 1);

    // R9 next sync after loss is candidate; R8 restart on new position
    frame(11, -1);
    chk("R9 first candidate after loss", int'(start_pos), 11);
    frame(3, -1);
    chk("R8 restart position", int'(start_pos), 3);
    frame(3, -1);
    chk("R8 count restarted at one", int'(locked), 0);
    frame(3, -1);
    chk("R8 lock at new position", int'(locked), 1);

    // R9 candidate discarded by a missing frame
    frame(-1, -1);
    frame(-1, -1);
    frame(7, -1);
    frame(-1, -1);
    frame(7, -1);
    frame(7, -1);
    chk("R9 candidate discarded", int'(locked), 0);
    frame(7, -1);
    chk("R9 lock after fresh three", int'(locked), 1);

    // randomized mix
    for (int blk = 0; blk < 8; blk++) begin
      int rp = $urandom % FL;
      for (int i = 0; i < 600; i++) begin
        bit s = ($urandom % 4) != 0;
        bit y = s && ((m_pos == rp) ? (($urandom % 10) != 0) : (($urandom % 25) == 0));
        bit w = ($urandom % 20) == 0;
        bit d = $urandom % 2;
        tick(s, y, w, d);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule